// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt lines, if any, should be raised toward the processor. It takes the pending-request, in-service and mask vectors of one controller, a rotation base, and a nesting-mode flag with a master/slave indication. It returns a registered valid bit and the line number of the winning request. Priority is counted from the rotation base upward and wraps past the top line. A lower count is more urgent.

A candidate request wins only when it is strictly more urgent than the most urgent line already in service. A master controller in special fully nested mode leaves the in-service bit of its cascade line out of that comparison, so a further request from the cascaded controller can still get through. The block also has a general priority probe: any 8-bit vector put on its input comes back as the priority number of its most urgent set bit, counted from the same base. The register file, acknowledge handling, cascading and vector formation live elsewhere.

Top module: `irq_rot_resolver`

## Requirements
- R1: The priority number of line L is (L - base) mod 8, and among candidate requests the one with the smallest priority number wins.
- R2: `probe_prio_o` gives the priority number (R1 numbering) of the most urgent set bit of `probe_vec_i`. For an all-zero vector it gives 8.
- R3: A request whose mask bit is 1 is never a candidate, whatever its priority.
- R4: A request is raised only if its priority number is strictly smaller than that of the most urgent in-service line. A request on an in-service line of equal or better priority is held off.
- R5: When `nested_i` and `master_i` are both 1, the in-service bit of the cascade line (line 2) is ignored for R4. Otherwise it counts like any other line.
- R6: `irq_line_o` equals (winning priority number + base) mod 8, and so names the physical line that wins.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency). They stay unchanged while the inputs stay unchanged.
- R8: When no request qualifies, `irq_valid_o` is 0 and `irq_line_o` is 0.
- R9: While `rst_n` is low, `irq_valid_o` is 0, `irq_line_o` is 0 and `probe_prio_o` is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Pending requests, bit n = line n |
| svc_i | input | 8 | In-service lines, bit n = line n |
| mask_i | input | 8 | Mask, bit n = 1 blocks line n |
| base_i | input | 3 | Rotation base: the line with priority number 0 |
| nested_i | input | 1 | Special fully nested mode enable |
| master_i | input | 1 | 1 when this controller is the cascade master |
| probe_vec_i | input | 8 | Arbitrary vector for the priority probe |
| irq_valid_o | output | 1 | A request should be raised |
| irq_line_o | output | 3 | Winning line number, 0 when none |
| probe_prio_o | output | 4 | Priority number of the probe vector, 8 when empty |

## Verification
The bench builds the block with its default parameters: eight lines, with line 2 as the cascade line. The 3-bit base therefore reaches every rotation, including those where the winning line wraps from 7 back to 0. Line 2 is also reachable both as a request and as an in-service bit, so the nested-mode exemption can be set against the plain master and slave cases on the same stimulus. The equal-priority hold-off and the all-zero probe result of 8 are exercised at the exact boundary values.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;
    localparam int unsigned IRQ_LINES   = 8;
    localparam int unsigned IRQ_CASCADE = 2;
endpackage

// File: rtl/rot_prio_scan.sv
module rot_prio_scan #(
    parameter int unsigned NL = 8,
    localparam int unsigned IW = $clog2(NL)
) (
    input  logic [NL-1:0] vec_i,
    input  logic [IW-1:0] base_i,
    output logic [IW:0]   prio_o
);
    logic [IW-1:0] idx;

    always_comb begin
        prio_o = (IW+1)'(NL);
        idx    = '0;
        for (int k = NL - 1; k >= 0; k--) begin
            idx = base_i + IW'(k);
            if (vec_i[idx]) prio_o = (IW+1)'(k);
        end
    end
endmodule

// File: rtl/svc_filter.sv
module svc_filter #(
    parameter int unsigned NL = 8,
    parameter int unsigned CASCADE = 2
) (
    input  logic [NL-1:0] svc_i,
    input  logic          exempt_i,
    output logic [NL-1:0] svc_o
);
    always_comb begin
        svc_o = svc_i;
        if (exempt_i) svc_o[CASCADE] = 1'b0;
    end
endmodule

// File: rtl/irq_rot_resolver.sv
module irq_rot_resolver
    import irq_rot_pkg::*;
#(
    parameter int unsigned NL      = IRQ_LINES,
    parameter int unsigned CASCADE = IRQ_CASCADE,
    localparam int unsigned IW     = $clog2(NL),
    localparam int unsigned NSCAN  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] req_i,
    input  logic [NL-1:0] svc_i,
    input  logic [NL-1:0] mask_i,
    input  logic [IW-1:0] base_i,
    input  logic          nested_i,
    input  logic          master_i,
    input  logic [NL-1:0] probe_vec_i,
    output logic          irq_valid_o,
    output logic [IW-1:0] irq_line_o,
    output logic [IW:0]   probe_prio_o
);
    typedef struct packed {
        logic          valid;
        logic [IW-1:0] line;
        logic [IW:0]   probe;
    } res_t;

    localparam res_t RES_RST = '{valid: 1'b0, line: '0, probe: (IW+1)'(NL)};

    logic [NL-1:0] svc_eff;
    logic [NL-1:0] scan_vec [NSCAN];
    logic [IW:0]   scan_prio [NSCAN];
    res_t          res_d, res_q;

    svc_filter #(.NL(NL), .CASCADE(CASCADE)) u_svc_filter (
        .svc_i    (svc_i),
        .exempt_i (nested_i & master_i),
        .svc_o    (svc_eff)
    );

    assign scan_vec[0] = req_i & ~mask_i;
    assign scan_vec[1] = svc_eff;
    assign scan_vec[2] = probe_vec_i;

    for (genvar g = 0; g < NSCAN; g++) begin : g_scan
        rot_prio_scan #(.NL(NL)) u_scan (
            .vec_i  (scan_vec[g]),
            .base_i (base_i),
            .prio_o (scan_prio[g])
        );
    end

    always_comb begin
        res_d       = RES_RST;
        res_d.probe = scan_prio[2];
        if (scan_prio[0] < scan_prio[1]) begin
            res_d.valid = 1'b1;
            res_d.line  = scan_prio[0][IW-1:0] + base_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RES_RST;
        else        res_q <= res_d;
    end

    assign irq_valid_o  = res_q.valid;
    assign irq_line_o   = res_q.line;
    assign probe_prio_o = res_q.probe;

    // Checker state: cycles seen since reset, and a bundle of all inputs
    logic       seen1_q, seen2_q;
    logic [4*NL+IW+1:0] in_bus;
    assign in_bus = {req_i, svc_i, mask_i, base_i, nested_i, master_i, probe_vec_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen1_q <= 1'b0;
            seen2_q <= 1'b0;
        end else begin
            seen1_q <= 1'b1;
            seen2_q <= seen1_q;
        end
    end

    // R8: idle means line zero
    a_r8_idle_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> irq_line_o == '0);

    // R3: a raised line was an unmasked request in the previous cycle
    a_r3_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1_q && irq_valid_o) |-> |($past(req_i & ~mask_i) & (NL'(1) << irq_line_o)));

    // R4: an in-service line at priority zero blocks everything
    a_r4_top_svc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1_q && $past(svc_i[base_i])
         && !($past(nested_i & master_i) && $past(base_i) == IW'(CASCADE)))
        |-> !irq_valid_o);

    // R2: empty probe vector reports NL
    a_r2_probe_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (seen1_q && $past(probe_vec_i) == '0) |-> probe_prio_o == (IW+1)'(NL));

    // R7: unchanged inputs give unchanged outputs
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen2_q && $past(in_bus) == $past(in_bus, 2))
        |-> ($stable(irq_valid_o) && $stable(irq_line_o) && $stable(probe_prio_o)));
endmodule

// File: tb/irq_rot_resolver_bench.sv
module irq_rot_resolver_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0, svc = '0, mask = '0, pvec = '0;
    logic [2:0] base = '0;
    logic       nested = 1'b0, master = 1'b0;
    logic       valid;
    logic [2:0] line;
    logic [3:0] pprio;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_rot_resolver u_irq_rot_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .svc_i(svc), .mask_i(mask),
        .base_i(base), .nested_i(nested), .master_i(master), .probe_vec_i(pvec),
        .irq_valid_o(valid), .irq_line_o(line), .probe_prio_o(pprio)
    );

    task automatic check(string tag, logic ev, logic [2:0] el, logic [3:0] ep);
        n_checks++;
        if (valid !== ev || line !== el || pprio !== ep) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b line=%0d probe=%0d, expected valid=%0b line=%0d probe=%0d",
                     tag, valid, line, pprio, ev, el, ep);
        end
    endtask

    // drive at a falling edge, wait one rising edge, sample at the next falling edge
    task automatic apply(string tag, logic [7:0] r, logic [7:0] s, logic [7:0] m,
                         logic [2:0] b, logic n, logic ms, logic [7:0] p,
                         logic ev, logic [2:0] el, logic [3:0] ep);
        @(negedge clk);
        req = r; svc = s; mask = m; base = b; nested = n; master = ms; pvec = p;
        @(negedge clk);
        check(tag, ev, el, ep);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset state", 1'b0, 3'd0, 4'd8);
        rst_n = 1'b1;
    endtask

    task automatic t_rotation;
        apply("R1 base0 lines3,5", 8'h28, 0, 0, 3'd0, 0, 0, 8'h28, 1, 3'd3, 4'd3);
        apply("R1 base4 lines3,5", 8'h28, 0, 0, 3'd4, 0, 0, 8'h28, 1, 3'd5, 4'd1);
        apply("R6 base6 wrap to line0", 8'h01, 0, 0, 3'd6, 0, 0, 8'h80, 1, 3'd0, 4'd1);
        apply("R6 base7 line6 last", 8'h40, 0, 0, 3'd7, 0, 0, 8'h40, 1, 3'd6, 4'd7);
    endtask

    task automatic t_mask;
        apply("R3 mask line3", 8'h28, 0, 8'h08, 3'd0, 0, 0, 8'h00, 1, 3'd5, 4'd8);
        apply("R3 R8 all masked", 8'h28, 0, 8'h28, 3'd0, 0, 0, 8'h00, 0, 3'd0, 4'd8);
    endtask

    task automatic t_strict;
        apply("R4 equal priority held", 8'h08, 8'h08, 0, 3'd0, 0, 0, 0, 0, 3'd0, 4'd8);
        apply("R4 lower svc passes", 8'h08, 8'h10, 0, 3'd0, 0, 0, 0, 1, 3'd3, 4'd8);
        apply("R4 higher svc blocks", 8'h08, 8'h04, 0, 3'd0, 0, 0, 0, 0, 3'd0, 4'd8);
        apply("R4 rotated svc passes", 8'h08, 8'h04, 0, 3'd3, 0, 0, 0, 1, 3'd3, 4'd8);
    endtask

    task automatic t_nested;
        apply("R5 nested master exempt", 8'h04, 8'h04, 0, 3'd0, 1, 1, 0, 1, 3'd2, 4'd8);
        apply("R5 nested slave counts", 8'h04, 8'h04, 0, 3'd0, 1, 0, 0, 0, 3'd0, 4'd8);
        apply("R5 plain master counts", 8'h04, 8'h04, 0, 3'd0, 0, 1, 0, 0, 3'd0, 4'd8);
        apply("R5 other svc still counts", 8'h04, 8'h06, 0, 3'd0, 1, 1, 0, 0, 3'd0, 4'd8);
    endtask

    task automatic t_probe;
        apply("R2 empty probe", 0, 0, 0, 3'd3, 0, 0, 8'h00, 0, 3'd0, 4'd8);
        apply("R2 probe line0 base3", 0, 0, 0, 3'd3, 0, 0, 8'h01, 0, 3'd0, 4'd5);
        apply("R2 probe full vector", 0, 0, 0, 3'd5, 0, 0, 8'hFF, 0, 3'd0, 4'd0);
    endtask

    task automatic t_latency;
        apply("R7 setup", 8'h80, 0, 0, 3'd0, 0, 0, 8'h80, 1, 3'd7, 4'd7);
        @(negedge clk);
        req = 8'h02; pvec = 8'h02;
        #1;
        check("R7 no change before edge", 1'b1, 3'd7, 4'd7);
        @(negedge clk);
        check("R7 updated after one edge", 1'b1, 3'd1, 4'd1);
        repeat (3) @(negedge clk);
        check("R7 held while stable", 1'b1, 3'd1, 4'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_mask();
        t_strict();
        t_nested();
        t_probe();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule